// File: doc/BRIEF.md
# Load Data Byte-Lane Aligner

This block sits on the load return path between a word-wide memory port and a pipelined processor. Memory always returns a full word from a word-aligned address. The two low-order bits of the original byte address never reach the bus; they travel beside the load instead. The aligner uses them, together with an access size, to move the addressed byte or halfword down into the least-significant byte lanes. Every lane above the extracted value is cleared to zero. Any sign extension for signed loads stays with the processor.

An access is misaligned when a halfword has an odd offset, when a word has any non-zero offset, or when the reserved size code is used. For such an access the block raises a flag and hands back the fetched word unshifted. Size, offset and data are all captured in the same cycle as the input strobe, so each load in a back-to-back stream is aligned on its own terms. Result, flag and output strobe come from registers, one clock after the input.

Top module: `load_align`

## Requirements
- R1: With size code 2'b10 (word) and offset 2'b00, out_data equals in_word and out_misaligned is 0.
- R2: With size code 2'b01 (halfword) and offset 2'b00, out_data[15:0] equals in_word[15:0], out_data[31:16] is zero and the flag is 0.
- R3: With size code 2'b01 and offset 2'b10, out_data[15:0] equals in_word[31:16], out_data[31:16] is zero and the flag is 0. For example, 0x87654321 gives 0x00008765.
- R4: With size code 2'b00 (byte), out_data[7:0] takes in_word bits [8*offset+7 : 8*offset] and out_data[31:8] is zero, for every offset. For example, 0x87654321 at offset 2'b11 gives 0x00000087. The flag is 0.
- R5: With size code 2'b01 and offset bit 0 set, out_misaligned is 1 and out_data equals in_word unshifted.
- R6: With size code 2'b10 and a non-zero offset, out_misaligned is 1 and out_data equals in_word unshifted.
- R7: Size code 2'b11 is reserved. It always sets out_misaligned and passes in_word unshifted, whatever the offset.
- R8: out_valid is in_valid delayed by exactly one clock. out_data and out_misaligned belong to the access presented on the previous clock.
- R9: While rst_n is low at a rising edge, out_valid, out_data and out_misaligned all become zero on that edge.
- R10: On a clock where in_valid is low, out_data and out_misaligned keep their previous values. in_word, in_offset and in_size are then ignored.
- R11: Loads on consecutive clocks with different sizes and offsets each produce their own correctly aligned result, with no carry-over between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A fetched word and its access attributes are present |
| in_word | input | 32 | Word returned from the word-aligned memory address |
| in_offset | input | 2 | Low two bits of the original byte address |
| in_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| out_valid | output | 1 | Registered result strobe |
| out_data | output | 32 | Aligned, zero-filled load data |
| out_misaligned | output | 1 | The access held in the output register was misaligned |

## Verification
A wrong lane selection shows up as the wrong byte or halfword in the low bits of out_data. A missing zero fill shows up as non-zero upper lanes. Either one appears on the clock right after the offending load, so each result is compared in the cycle it emerges. A flaw in the capture or hold registers shows up differently: a result left over from an earlier load, or a value that changes during idle cycles. The bench therefore checks the outputs on every cycle, including idle ones and loads issued back to back.

// File: rtl/load_align_pkg.sv
// Package: shared access-size encoding for the load aligner.
// Assumes: a two-bit size field supplied by the load pipeline.
package load_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/lane_extract.sv
// lane_extract: combinational lane steering. It picks the byte or halfword
// selected by the offset, moves it to the bottom lanes and zero-fills above.
// Assumes: DATA_W is a multiple of 16. Misalignment is handled elsewhere;
// for a halfword only the upper offset bits are used.
module lane_extract
    import load_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int HALVES = DATA_W / 16,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  acc_size_e         size_i,
    output logic [DATA_W-1:0] data_o
);

    logic [7:0]  byte_lane [LANES];
    logic [15:0] half_lane [HALVES];

    // Split the word into byte lanes.
    for (genvar i = 0; i < LANES; i++) begin : g_byte
        assign byte_lane[i] = word_i[8*i +: 8];
    end

    // Split the word into halfword lanes.
    for (genvar j = 0; j < HALVES; j++) begin : g_half
        assign half_lane[j] = word_i[16*j +: 16];
    end

    // Choose the lane by size and offset, zero-filling the upper lanes.
    always_comb begin
        data_o = '0;
        unique case (size_i)
            SZ_BYTE: data_o[7:0]  = byte_lane[offset_i];
            SZ_HALF: data_o[15:0] = half_lane[offset_i[OFF_W-1:1]];
            default: data_o       = word_i;
        endcase
    end

endmodule

// File: rtl/misalign_check.sv
// misalign_check: decides whether an access breaks its natural alignment.
// Assumes: byte accesses never misalign and the reserved size is always flagged.
module misalign_check
    import load_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] offset_i,
    input  acc_size_e        size_i,
    output logic             misaligned_o
);

    // Flag an offset that is not a multiple of the access size.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: misaligned_o = 1'b0;
            SZ_HALF: misaligned_o = offset_i[0];
            SZ_WORD: misaligned_o = |offset_i;
            default: misaligned_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/align_out_reg.sv
// align_out_reg: output register stage. It loads the result and flag on an
// input strobe and delays the strobe by one clock.
// Assumes: synchronous active-low reset; data holds while no strobe arrives.
module align_out_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              mis_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              mis_o
);

    // Delay the strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // Capture the result and flag only when a load is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            mis_o  <= 1'b0;
        end else if (valid_i) begin
            data_o <= data_i;
            mis_o  <= mis_i;
        end
    end

endmodule

// File: rtl/load_align.sv
// load_align: top of the load data aligner. The fetched word, offset and
// size are taken in the same cycle; the aligned result comes out one clock later.
// Assumes: the memory word comes from the word-aligned address and the
// processor handles any sign extension.
module load_align
    import load_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_word,
    input  logic [OFF_W-1:0]  in_offset,
    input  logic [1:0]        in_size,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_misaligned
);

    acc_size_e         size_e;
    logic [DATA_W-1:0] steered;
    logic              mis;
    logic [DATA_W-1:0] next_data;

    assign size_e = acc_size_e'(in_size);

    lane_extract #(.DATA_W(DATA_W)) u_lanes (
        .word_i   (in_word),
        .offset_i (in_offset),
        .size_i   (size_e),
        .data_o   (steered)
    );

    misalign_check #(.OFF_W(OFF_W)) u_mis (
        .offset_i     (in_offset),
        .size_i       (size_e),
        .misaligned_o (mis)
    );

    // A misaligned access returns the raw word; otherwise the steered lanes.
    always_comb begin
        next_data = mis ? in_word : steered;
    end

    align_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .data_i  (next_data),
        .mis_i   (mis),
        .valid_o (out_valid),
        .data_o  (out_data),
        .mis_o   (out_misaligned)
    );

endmodule

// File: rtl/load_align_chk.sv
// load_align_chk: temporal properties of the aligner, bound to its top.
// Assumes: it observes only the ports of load_align.
module load_align_chk #(
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(DATA_W / 8)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_word,
    input logic [OFF_W-1:0]  in_offset,
    input logic [1:0]        in_size,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_misaligned
);

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> ($stable(out_data) && $stable(out_misaligned)));

    p_byte_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'b00) |=> (out_data[DATA_W-1:8] == '0 && !out_misaligned));

    p_half_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'b01 && !in_offset[0]) |=> (out_data[DATA_W-1:16] == '0));

    p_word_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'b10 && in_offset != '0) |=>
        (out_misaligned && out_data == $past(in_word)));

    p_reserved_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'b11) |=> (out_misaligned && out_data == $past(in_word)));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && !out_misaligned));

endmodule

bind load_align load_align_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_word        (in_word),
    .in_offset      (in_offset),
    .in_size        (in_size),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .out_misaligned (out_misaligned)
);

// File: tb/load_align_test.sv
// load_align_test: directed and seeded-random loads checked against a
// reference model built from the requirements.
module load_align_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [1:0]  in_offset = '0;
    logic [1:0]  in_size = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_misaligned;

    int total = 0;
    int bad = 0;

    logic        exp_valid = 1'b0;
    logic [31:0] exp_data = '0;
    logic        exp_mis = 1'b0;
    string       exp_tag = "R9";

    always #10 clk = ~clk;

    load_align uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_word        (in_word),
        .in_offset      (in_offset),
        .in_size        (in_size),
        .out_valid      (out_valid),
        .out_data       (out_data),
        .out_misaligned (out_misaligned)
    );

    function automatic logic model_mis(logic [1:0] off, logic [1:0] sz);
        case (sz)
            2'b00:   return 1'b0;
            2'b01:   return off[0];
            2'b10:   return off != 2'b00;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] model_data(logic [31:0] w, logic [1:0] off, logic [1:0] sz);
        if (model_mis(off, sz)) return w;
        case (sz)
            2'b00:   return {24'h0, w[8*off +: 8]};
            2'b01:   return off[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
            default: return w;
        endcase
    endfunction

    function automatic string model_tag(logic [1:0] off, logic [1:0] sz);
        case (sz)
            2'b00:   return "R4";
            2'b01:   return off[0] ? "R5" : (off[1] ? "R3" : "R2");
            2'b10:   return (off == 2'b00) ? "R1" : "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare outputs with the model, then present the next cycle's inputs.
    task automatic step(logic v, logic [31:0] w, logic [1:0] off, logic [1:0] sz);
        @(negedge clk);
        check("R8", "out_valid", {31'h0, out_valid}, {31'h0, exp_valid});
        check(exp_tag, "out_data", out_data, exp_data);
        check(exp_tag, "out_misaligned", {31'h0, out_misaligned}, {31'h0, exp_mis});
        in_valid  = v;
        in_word   = w;
        in_offset = off;
        in_size   = sz;
        exp_valid = v;
        if (v) begin
            exp_data = model_data(w, off, sz);
            exp_mis  = model_mis(off, sz);
            exp_tag  = model_tag(off, sz);
        end else begin
            exp_tag = "R10";
        end
    endtask

    // Hold reset across an edge with a live strobe; outputs must clear.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_word = 32'hDEADBEEF;
        in_size = 2'b10;
        in_offset = 2'b00;
        @(negedge clk);
        check("R9", "out_valid", {31'h0, out_valid}, 32'h0);
        check("R9", "out_data", out_data, 32'h0);
        check("R9", "out_misaligned", {31'h0, out_misaligned}, 32'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        exp_valid = 1'b0;
        exp_data = '0;
        exp_mis = 1'b0;
        exp_tag = "R9";
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd4711;
        logic [31:0] w;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        do_reset();
        // Directed: every byte offset, both halfwords, word (R1..R4).
        for (int o = 0; o < 4; o++) step(1'b1, 32'h87654321, 2'(o), 2'b00);
        step(1'b1, 32'h87654321, 2'b00, 2'b01);
        step(1'b1, 32'h87654321, 2'b10, 2'b01);
        step(1'b1, 32'h87654321, 2'b00, 2'b10);
        // Misaligned and reserved cases (R5, R6, R7).
        step(1'b1, 32'hA1B2C3D4, 2'b01, 2'b01);
        step(1'b1, 32'hA1B2C3D4, 2'b11, 2'b01);
        for (int o = 1; o < 4; o++) step(1'b1, 32'h0F1E2D3C, 2'(o), 2'b10);
        for (int o = 0; o < 4; o++) step(1'b1, 32'h55AA33CC, 2'(o), 2'b11);
        // Idle cycles with changing inputs must be ignored (R10).
        step(1'b0, 32'hFFFFFFFF, 2'b11, 2'b00);
        step(1'b0, 32'h12345678, 2'b10, 2'b01);
        // Back-to-back loads, differing sizes (R11).
        step(1'b1, 32'hCAFEF00D, 2'b11, 2'b00);
        step(1'b1, 32'hCAFEF00D, 2'b10, 2'b01);
        step(1'b1, 32'hCAFEF00D, 2'b01, 2'b00);
        step(1'b0, 32'h0, 2'b00, 2'b00);
        // Seeded random mix (R11).
        for (int n = 0; n < 400; n++) begin
            w = $urandom;
            step(($urandom % 4) != 0, w, 2'($urandom), 2'($urandom));
        end
        step(1'b0, 32'h0, 2'b00, 2'b00);
        // Reset in mid-stream, then resume (R9).
        step(1'b1, 32'h13579BDF, 2'b10, 2'b00);
        do_reset();
        step(1'b1, 32'h2468ACE0, 2'b11, 2'b00);
        step(1'b0, 32'h0, 2'b00, 2'b00);
        step(1'b0, 32'h0, 2'b00, 2'b00);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule